// File: doc/BRIEF.md
# Acknowledged Byte Transaction Slave

This block answers a host that talks to it one byte at a time. Each host byte arrives as a single-cycle `rx_valid` strobe with `rx_data`. The engine returns one reply byte on `tx_valid`/`tx_data` for every host byte except the host's closing acknowledge. A transaction opens with a device address byte whose low bit picks write or read. For a write, the host then sends a command byte and a 16-bit word, low byte first, and the engine answers each byte with an increasing acknowledge number. For a read, the engine fetches a 16-bit word from a register port using the command byte as the index. It sends the word back one byte at a time and checks the host's acknowledge after each byte.

An optional checksum mode protects both directions. Once it is on, a write carries a trailing checksum byte that must match before the word is released. A read can then ask the engine for a checksum byte. The host turns the mode on or off with the acknowledge value it sends after the high read byte. The setting holds across transactions. If the host sends an acknowledge value that is not allowed at that point, the engine treats it as a collision: it drops the transaction at once and sends no reply.

Results are reported as single-cycle pulses: a committed write, a finished read, a collision, or a checksum error. Command decoding and storage sit outside this block.

Top module: `xact_slave`

## Requirements
- R1: In idle, byte 0x12 opens a write and byte 0x13 opens a read (device address 0x09 in bits 7:1, bit 0 set for read). Each is answered with 0x00. Any other byte in idle gets no reply and leaves the engine idle.
- R2: With checksum mode off, the write bytes (address, command, data low, data high) are answered with 0x00, 0x01, 0x02 and 0xFF. `wr_commit` pulses for one cycle in the cycle the 0xFF reply appears, with `wr_cmd` = command and `wr_data` = {data high, data low}. `wr_cmd` and `wr_data` change only on a commit.
- R3: With checksum mode on, a write is answered with 0x00, 0x01, 0x02 and 0x03, and the host then sends a checksum byte. If the checksum matches, the reply is 0xFF and the write commits. If it does not match, the reply is 0xEE, `csum_err` pulses for one cycle, nothing is committed and checksum mode stays on.
- R4: The checksum is the two's complement, modulo 256, of the sum of the address, command, data low and data high bytes of the transaction. Example: 0x12, 0xC0, 0x03, 0x10 give 0x1B.
- R5: For a read, the command byte produces a one-cycle `rd_en` with `rd_addr` = command. `rd_data` is taken one cycle after `rd_en`. The reply to the command byte is `rd_data[7:0]`. A host acknowledge of 0x02 is then answered with `rd_data[15:8]`.
- R6: After the high read byte, a host byte of 0xFF ends the read with a one-cycle `rd_done` and no reply, and leaves checksum mode off. If checksum mode was on, this turns it off.
- R7: With checksum mode off, a host byte of 0x03 after the high read byte turns checksum mode on, pulses `rd_done` and gives no reply.
- R8: With checksum mode on, a host byte of 0x03 after the high read byte is answered with the R4 checksum over 0x13, command, data low and data high. A following 0xFF pulses `rd_done` with no reply and leaves checksum mode on.
- R9: Any other host byte where 0x02 (after data low), 0x03 or 0xFF (after data high) or 0xFF (after the read checksum) is expected causes a one-cycle `collision` with no reply and no `rd_done`. The engine returns to idle and checksum mode is unchanged.
- R10: A synchronous active-high reset returns the engine to idle, turns checksum mode off and clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Host byte strobe |
| rx_data | input | 8 | Host byte |
| tx_valid | output | 1 | Reply byte strobe |
| tx_data | output | 8 | Reply byte |
| rd_en | output | 1 | Read request to the register port |
| rd_addr | output | 8 | Read index (the command byte) |
| rd_data | input | 16 | Read word, valid one cycle after rd_en |
| wr_commit | output | 1 | One-cycle pulse when a write is released |
| wr_cmd | output | 8 | Command of the last committed write |
| wr_data | output | 16 | Word of the last committed write |
| rd_done | output | 1 | One-cycle pulse when a read finishes |
| collision | output | 1 | One-cycle pulse on a wrong host acknowledge |
| csum_err | output | 1 | One-cycle pulse on a write checksum mismatch |
| csum_mode | output | 1 | Checksum mode is on |

## Verification
The hardest states to reach from the ports are the ones behind checksum mode. A write checksum mismatch and a read checksum reply only occur after an earlier read has ended with the 0x03 acknowledge. The stimulus first runs a normal read that ends that way. It then runs a good checksum write and a deliberately corrupted one in the same mode, and checks that the stored word survives the corrupted one. Collisions are forced at each acknowledge point, with checksum mode both off and on. Reset is applied in the middle of a checksum-mode write to show that the mode flag returns to off.

// File: rtl/xact_pkg.sv
package xact_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_W_CMD,
    S_W_LO,
    S_W_HI,
    S_W_SUM,
    S_R_CMD,
    S_R_WAIT,
    S_R_CAP,
    S_R_ACK_LO,
    S_R_ACK_HI,
    S_R_ACK_SUM
  } xact_state_t;

  localparam logic [7:0] REP_SEQ0 = 8'h00;
  localparam logic [7:0] REP_SEQ1 = 8'h01;
  localparam logic [7:0] REP_SEQ2 = 8'h02;
  localparam logic [7:0] REP_SEQ3 = 8'h03;
  localparam logic [7:0] REP_END  = 8'hFF;
  localparam logic [7:0] REP_BAD  = 8'hEE;

endpackage

// File: rtl/xact_sum.sv
module xact_sum #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [BYTE_W-1:0] ld_val,
  input  logic              add,
  input  logic [BYTE_W-1:0] add_a,
  input  logic [BYTE_W-1:0] add_b,
  output logic [BYTE_W-1:0] sum,
  output logic [BYTE_W-1:0] neg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum <= '0;
    end else if (ld) begin
      sum <= ld_val;
    end else if (add) begin
      sum <= sum + add_a + add_b;
    end
  end

  assign neg = ~sum + BYTE_W'(1);

endmodule

// File: rtl/xact_mode.sv
module xact_mode (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic mode
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= 1'b0;
    end else if (set) begin
      mode <= 1'b1;
    end else if (clr) begin
      mode <= 1'b0;
    end
  end

  // R6 R7
  setclr_excl_chk: assert property (@(posedge clk) disable iff (rst) !(set && clr));

endmodule

// File: rtl/xact_reply.sv
module xact_reply #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= send;
      if (send) tx_data <= byte_in;
    end
  end

endmodule

// File: rtl/xact_slave.sv
module xact_slave
  import xact_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-2:0] DEV_ADDR = 'h09,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              rd_en,
  output logic [BYTE_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              wr_commit,
  output logic [BYTE_W-1:0] wr_cmd,
  output logic [WORD_W-1:0] wr_data,
  output logic              rd_done,
  output logic              collision,
  output logic              csum_err,
  output logic              csum_mode
);

  localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};
  localparam logic [BYTE_W-1:0] ADDR_RD = {DEV_ADDR, 1'b1};

  xact_state_t st, st_n;

  logic [BYTE_W-1:0] cmd_q, lo_q, hi_q;
  logic [WORD_W-1:0] word_q;

  logic              send;
  logic [BYTE_W-1:0] send_byte;
  logic              sum_ld, sum_add;
  logic [BYTE_W-1:0] add_a, add_b;
  logic [BYTE_W-1:0] sum_q, sum_neg, sum_tot;
  logic              sum_ok;
  logic              m_set, m_clr;
  logic              commit_n, rdone_n, coll_n, cerr_n, rd_en_n;
  logic              cap_cmd, cap_lo, cap_hi, cap_word;
  logic [BYTE_W-1:0] commit_hi;

  assign sum_tot = sum_q + rx_data;
  assign sum_ok  = (sum_tot == '0);

  xact_sum #(.BYTE_W(BYTE_W)) u_sum (
    .clk(clk), .rst(rst), .ld(sum_ld), .ld_val(rx_data), .add(sum_add),
    .add_a(add_a), .add_b(add_b), .sum(sum_q), .neg(sum_neg)
  );

  xact_mode u_mode (
    .clk(clk), .rst(rst), .set(m_set), .clr(m_clr), .mode(csum_mode)
  );

  xact_reply #(.BYTE_W(BYTE_W)) u_reply (
    .clk(clk), .rst(rst), .send(send), .byte_in(send_byte),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  always_comb begin
    st_n      = st;
    send      = 1'b0;
    send_byte = '0;
    sum_ld    = 1'b0;
    sum_add   = 1'b0;
    add_a     = rx_data;
    add_b     = '0;
    m_set     = 1'b0;
    m_clr     = 1'b0;
    commit_n  = 1'b0;
    rdone_n   = 1'b0;
    coll_n    = 1'b0;
    cerr_n    = 1'b0;
    rd_en_n   = 1'b0;
    cap_cmd   = 1'b0;
    cap_lo    = 1'b0;
    cap_hi    = 1'b0;
    cap_word  = 1'b0;
    commit_hi = hi_q;
    case (st)
      S_IDLE: begin
        if (rx_valid) begin
          if (rx_data == ADDR_WR) begin
            st_n = S_W_CMD; send = 1'b1; send_byte = BYTE_W'(REP_SEQ0); sum_ld = 1'b1;
          end else if (rx_data == ADDR_RD) begin
            st_n = S_R_CMD; send = 1'b1; send_byte = BYTE_W'(REP_SEQ0); sum_ld = 1'b1;
          end
        end
      end
      S_W_CMD: begin
        if (rx_valid) begin
          cap_cmd = 1'b1; sum_add = 1'b1;
          send = 1'b1; send_byte = BYTE_W'(REP_SEQ1); st_n = S_W_LO;
        end
      end
      S_W_LO: begin
        if (rx_valid) begin
          cap_lo = 1'b1; sum_add = 1'b1;
          send = 1'b1; send_byte = BYTE_W'(REP_SEQ2); st_n = S_W_HI;
        end
      end
      S_W_HI: begin
        if (rx_valid) begin
          cap_hi = 1'b1; sum_add = 1'b1; send = 1'b1;
          if (csum_mode) begin
            send_byte = BYTE_W'(REP_SEQ3); st_n = S_W_SUM;
          end else begin
            send_byte = BYTE_W'(REP_END); commit_n = 1'b1;
            commit_hi = rx_data; st_n = S_IDLE;
          end
        end
      end
      S_W_SUM: begin
        if (rx_valid) begin
          send = 1'b1; st_n = S_IDLE;
          if (sum_ok) begin
            send_byte = BYTE_W'(REP_END); commit_n = 1'b1;
          end else begin
            send_byte = BYTE_W'(REP_BAD); cerr_n = 1'b1;
          end
        end
      end
      S_R_CMD: begin
        if (rx_valid) begin
          cap_cmd = 1'b1; sum_add = 1'b1; rd_en_n = 1'b1; st_n = S_R_WAIT;
        end
      end
      S_R_WAIT: st_n = S_R_CAP;
      S_R_CAP: begin
        cap_word = 1'b1; sum_add = 1'b1;
        add_a = rd_data[BYTE_W-1:0]; add_b = rd_data[WORD_W-1:BYTE_W];
        send = 1'b1; send_byte = rd_data[BYTE_W-1:0]; st_n = S_R_ACK_LO;
      end
      S_R_ACK_LO: begin
        if (rx_valid) begin
          if (rx_data == BYTE_W'(REP_SEQ2)) begin
            send = 1'b1; send_byte = word_q[WORD_W-1:BYTE_W]; st_n = S_R_ACK_HI;
          end else begin
            coll_n = 1'b1; st_n = S_IDLE;
          end
        end
      end
      S_R_ACK_HI: begin
        if (rx_valid) begin
          st_n = S_IDLE;
          if (rx_data == BYTE_W'(REP_SEQ3)) begin
            if (csum_mode) begin
              send = 1'b1; send_byte = sum_neg; st_n = S_R_ACK_SUM;
            end else begin
              m_set = 1'b1; rdone_n = 1'b1;
            end
          end else if (rx_data == BYTE_W'(REP_END)) begin
            m_clr = 1'b1; rdone_n = 1'b1;
          end else begin
            coll_n = 1'b1;
          end
        end
      end
      S_R_ACK_SUM: begin
        if (rx_valid) begin
          st_n = S_IDLE;
          if (rx_data == BYTE_W'(REP_END)) rdone_n = 1'b1;
          else coll_n = 1'b1;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cmd_q     <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      word_q    <= '0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      wr_commit <= 1'b0;
      wr_cmd    <= '0;
      wr_data   <= '0;
      rd_done   <= 1'b0;
      collision <= 1'b0;
      csum_err  <= 1'b0;
    end else begin
      st        <= st_n;
      rd_en     <= rd_en_n;
      wr_commit <= commit_n;
      rd_done   <= rdone_n;
      collision <= coll_n;
      csum_err  <= cerr_n;
      if (cap_cmd)  cmd_q  <= rx_data;
      if (cap_lo)   lo_q   <= rx_data;
      if (cap_hi)   hi_q   <= rx_data;
      if (cap_word) word_q <= rd_data;
      if (rd_en_n)  rd_addr <= rx_data;
      if (commit_n) begin
        wr_cmd  <= cmd_q;
        wr_data <= {commit_hi, lo_q};
      end
    end
  end

  // R2
  commit_on_byte_chk: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> $past(rx_valid));

  // R9
  coll_silent_chk: assert property (@(posedge clk) disable iff (rst)
    collision |-> (!tx_valid && !rd_done && !wr_commit));

  // R3
  cerr_in_mode_chk: assert property (@(posedge clk) disable iff (rst)
    csum_err |-> (csum_mode && !wr_commit && tx_valid));

  // R5
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

  // R7
  mode_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (csum_mode != $past(csum_mode))) |-> rd_done);

endmodule

// File: tb/sim_xact_slave.sv
`timescale 1ns/1ps
module sim_xact_slave;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data = 16'h0000;
  logic        wr_commit;
  logic [7:0]  wr_cmd;
  logic [15:0] wr_data;
  logic        rd_done, collision, csum_err, csum_mode;

  int checks = 0;
  int errors = 0;
  int n_commit = 0, n_rdone = 0, n_coll = 0, n_cerr = 0, n_rden = 0;
  logic [7:0] seen_addr = 8'h00;
  logic [7:0] c, l, h, k;
  logic [15:0] w;

  always #4 clk = ~clk;

  xact_slave u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_commit(wr_commit), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .rd_done(rd_done), .collision(collision), .csum_err(csum_err), .csum_mode(csum_mode)
  );

  function automatic logic [15:0] mem_f(input logic [7:0] a);
    return {a ^ 8'hA5, a + 8'h3C};
  endfunction

  function automatic logic [7:0] ck(input logic [7:0] a, b, d, e);
    logic [7:0] s;
    s = a + b + d + e;
    return 8'h00 - s;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mem_f(rd_addr);

  always @(negedge clk) begin
    if (wr_commit) n_commit++;
    if (rd_done)   n_rdone++;
    if (collision) n_coll++;
    if (csum_err)  n_cerr++;
    if (rd_en) begin n_rden++; seen_addr = rd_addr; end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clr_counts();
    n_commit = 0; n_rdone = 0; n_coll = 0; n_cerr = 0; n_rden = 0;
  endtask

  // Drive one host byte and watch for a reply in the following cycles.
  task automatic xfer(input logic [7:0] b, input bit exp_rep, input logic [7:0] exp, input string tag);
    bit got;
    logic [7:0] v;
    got = 1'b0; v = 8'h00;
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (tx_valid && !got) begin got = 1'b1; v = tx_data; end
      if (i < 5) @(negedge clk);
    end
    check({tag, " reply present"}, 32'(got), 32'(exp_rep));
    if (exp_rep && got) check({tag, " reply value"}, 32'(v), 32'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  localparam logic [23:0] WVEC [6] = '{
    24'h10_C0_03, 24'h00_00_00, 24'hFF_FF_FF,
    24'h5A_12_34, 24'h81_00_FF, 24'h33_AA_55
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 tx_valid", 32'(tx_valid), 0);
    check("R10 csum_mode", 32'(csum_mode), 0);
    check("R10 wr_data", 32'(wr_data), 0);
    check("R10 rd_en", 32'(rd_en), 0);

    // R2 vector table of normal-mode writes
    for (int i = 0; i < 6; i++) begin
      c = WVEC[i][23:16]; l = WVEC[i][15:8]; h = WVEC[i][7:0];
      clr_counts();
      xfer(8'h12, 1, 8'h00, "R1 write addr");
      xfer(c, 1, 8'h01, "R2 cmd");
      xfer(l, 1, 8'h02, "R2 lo");
      xfer(h, 1, 8'hFF, "R2 hi");
      check("R2 commit count", 32'(n_commit), 1);
      check("R2 wr_cmd", 32'(wr_cmd), 32'(c));
      check("R2 wr_data", 32'(wr_data), 32'({h, l}));
    end

    // R1 foreign addresses ignored
    xfer(8'h14, 0, 8'h00, "R1 addr 0x14");
    xfer(8'h02, 0, 8'h00, "R1 addr 0x02");
    xfer(8'h12, 1, 8'h00, "R1 write after junk");
    xfer(8'h44, 1, 8'h01, "R1 cmd after junk");
    xfer(8'h01, 1, 8'h02, "R1 lo after junk");
    xfer(8'h02, 1, 8'hFF, "R1 hi after junk");
    check("R1 data after junk", 32'(wr_data), 32'h0201);

    // R5 R6 normal read ending with 0xFF
    clr_counts();
    c = 8'h27; w = mem_f(c);
    xfer(8'h13, 1, 8'h00, "R5 read addr");
    xfer(c, 1, w[7:0], "R5 lo");
    check("R5 rd_en count", 32'(n_rden), 1);
    check("R5 rd_addr", 32'(seen_addr), 32'(c));
    xfer(8'h02, 1, w[15:8], "R5 hi");
    xfer(8'hFF, 0, 8'h00, "R6 close");
    check("R6 rd_done", 32'(n_rdone), 1);
    check("R6 mode off", 32'(csum_mode), 0);

    // R9 collision after low byte, then engine idle
    clr_counts();
    xfer(8'h13, 1, 8'h00, "R9 addr");
    xfer(8'h08, 1, mem_f(8'h08) & 16'h00FF, "R9 lo");
    xfer(8'h05, 0, 8'h00, "R9 bad ack lo");
    check("R9 collision", 32'(n_coll), 1);
    check("R9 no done", 32'(n_rdone), 0);
    xfer(8'h02, 0, 8'h00, "R9 idle after collision");

    // R9 collision after high byte
    clr_counts();
    w = mem_f(8'h09);
    xfer(8'h13, 1, 8'h00, "R9 addr2");
    xfer(8'h09, 1, w[7:0], "R9 lo2");
    xfer(8'h02, 1, w[15:8], "R9 hi2");
    xfer(8'h7F, 0, 8'h00, "R9 bad ack hi");
    check("R9 collision hi", 32'(n_coll), 1);
    check("R9 mode kept", 32'(csum_mode), 0);

    // R7 enable checksum mode
    clr_counts();
    w = mem_f(8'h30);
    xfer(8'h13, 1, 8'h00, "R7 addr");
    xfer(8'h30, 1, w[7:0], "R7 lo");
    xfer(8'h02, 1, w[15:8], "R7 hi");
    xfer(8'h03, 0, 8'h00, "R7 enable");
    check("R7 rd_done", 32'(n_rdone), 1);
    check("R7 mode on", 32'(csum_mode), 1);

    // R3 R4 checksum write good (example checksum 0x1B)
    clr_counts();
    k = ck(8'h12, 8'hC0, 8'h03, 8'h10);
    check("R4 example sum", 32'(k), 32'h1B);
    xfer(8'h12, 1, 8'h00, "R3 addr");
    xfer(8'hC0, 1, 8'h01, "R3 cmd");
    xfer(8'h03, 1, 8'h02, "R3 lo");
    xfer(8'h10, 1, 8'h03, "R3 hi");
    check("R3 no early commit", 32'(n_commit), 0);
    xfer(8'h1B, 1, 8'hFF, "R4 good sum");
    check("R3 commit", 32'(n_commit), 1);
    check("R3 wr_data", 32'(wr_data), 32'h1003);

    // R3 checksum write bad
    clr_counts();
    xfer(8'h12, 1, 8'h00, "R3 addr b");
    xfer(8'h66, 1, 8'h01, "R3 cmd b");
    xfer(8'h77, 1, 8'h02, "R3 lo b");
    xfer(8'h88, 1, 8'h03, "R3 hi b");
    xfer(ck(8'h12, 8'h66, 8'h77, 8'h88) + 8'h01, 1, 8'hEE, "R3 bad sum");
    check("R3 csum_err", 32'(n_cerr), 1);
    check("R3 no commit", 32'(n_commit), 0);
    check("R3 data kept", 32'(wr_data), 32'h1003);
    check("R3 mode kept", 32'(csum_mode), 1);

    // R8 checksum read
    clr_counts();
    c = 8'h5E; w = mem_f(c);
    xfer(8'h13, 1, 8'h00, "R8 addr");
    xfer(c, 1, w[7:0], "R8 lo");
    xfer(8'h02, 1, w[15:8], "R8 hi");
    xfer(8'h03, 1, ck(8'h13, c, w[7:0], w[15:8]), "R8 sum reply");
    xfer(8'hFF, 0, 8'h00, "R8 close");
    check("R8 rd_done", 32'(n_rdone), 1);
    check("R8 mode on", 32'(csum_mode), 1);

    // R9 collision after read checksum
    clr_counts();
    c = 8'h01; w = mem_f(c);
    xfer(8'h13, 1, 8'h00, "R9 addr3");
    xfer(c, 1, w[7:0], "R9 lo3");
    xfer(8'h02, 1, w[15:8], "R9 hi3");
    xfer(8'h03, 1, ck(8'h13, c, w[7:0], w[15:8]), "R9 sum3");
    xfer(8'h00, 0, 8'h00, "R9 bad final");
    check("R9 collision sum", 32'(n_coll), 1);
    check("R9 mode kept on", 32'(csum_mode), 1);

    // R6 disable checksum mode
    clr_counts();
    c = 8'hE0; w = mem_f(c);
    xfer(8'h13, 1, 8'h00, "R6 addr");
    xfer(c, 1, w[7:0], "R6 lo");
    xfer(8'h02, 1, w[15:8], "R6 hi");
    xfer(8'hFF, 0, 8'h00, "R6 disable");
    check("R6 done", 32'(n_rdone), 1);
    check("R6 mode off", 32'(csum_mode), 0);

    // R10 reset in the middle of a checksum-mode write
    xfer(8'h13, 1, 8'h00, "R10 addr");
    xfer(8'h02, 1, mem_f(8'h02) & 16'h00FF, "R10 lo");
    xfer(8'h02, 1, mem_f(8'h02) >> 8, "R10 hi");
    xfer(8'h03, 0, 8'h00, "R10 enable");
    xfer(8'h12, 1, 8'h00, "R10 w addr");
    xfer(8'h11, 1, 8'h01, "R10 w cmd");
    do_reset();
    @(negedge clk);
    check("R10 mode cleared", 32'(csum_mode), 0);
    check("R10 wr_data cleared", 32'(wr_data), 0);
    clr_counts();
    xfer(8'h12, 1, 8'h00, "R10 addr after");
    xfer(8'h21, 1, 8'h01, "R10 cmd after");
    xfer(8'h43, 1, 8'h02, "R10 lo after");
    xfer(8'h65, 1, 8'hFF, "R10 hi after");
    check("R10 normal write", 32'(wr_data), 32'h6543);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule